// File: doc/BRIEF.md
# BCD Time-of-Day Counter

This block holds the wall-clock time of day as three packed BCD fields (hours, minutes, seconds). An external time base supplies a one-cycle strobe once per second, and the block moves the time forward by one second on each strobe. Seconds wrap into minutes, minutes wrap into hours, and hours wrap from 23 back to 00.

A host can load any subset of the three fields in one cycle. Each field has its own enable bit. A field only takes the new value if its two BCD digits form a legal value for that field. Otherwise that field keeps its old value. A write always has priority over a strobe that arrives in the same cycle. That strobe is dropped.

A day-end flag is high for the whole second in which the time reads 23:59:59. A calendar stage can AND this flag with the next strobe to find the exact clock on which the day turns over. All pins are plain control and status signals. There is no valid/ready stream here, so the block applies no back-pressure.

Top module: `tod_bcd_counter`

## Requirements
- R1: While `rst_n` is low, the time is set to 00:00:00 and `day_last` is low.
- R2: The time advances by exactly one second on a cycle where `sec_tick` is high and `wr_en` is low. On every other cycle with no accepted write, the time is held.
- R3: When seconds read 59, the next advance sets seconds to 00 and adds one minute.
- R4: When minutes read 59 and seconds read 59, an advance sets minutes to 00 and adds one hour. From 23:59:59, an advance gives 00:00:00.
- R5: A seconds or minutes write value is accepted only when its low nibble is at most 9 and its high nibble is at most 5. A rejected field keeps its prior value.
- R6: An hours write value is the 6-bit slice `wr_time[21:16]`. It is accepted only when its low nibble is at most 9 and its value is at most 0x23. A rejected value leaves the hours unchanged.
- R7: `wr_field_en` bit 0 selects seconds, bit 1 selects minutes and bit 2 selects hours. A field whose bit is clear is not changed by the write, whatever its data bits hold.
- R8: When `wr_en` and `sec_tick` are high in the same cycle, the write is applied and that strobe is discarded. Fields that are not written keep their values and do not advance.
- R9: `day_last` is high exactly while the time reads 23:59:59.
- R10: The time is laid out as `time_now[7:0]` seconds, `[15:8]` minutes and `[21:16]` hours, each in packed BCD. The write data uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Host write strobe |
| wr_field_en | input | 3 | Per-field write enables: bit 0 seconds, bit 1 minutes, bit 2 hours |
| wr_time | input | 22 | Write data in the same BCD layout as `time_now` |
| time_now | output | 22 | Current time in packed BCD |
| day_last | output | 1 | High while the time reads 23:59:59 |

## Verification
Any fault in a field register or in the carry chain shows up on `time_now` one clock after the strobe or write that caused it. The time is visible on the ports every cycle, so a wrong digit, a missed carry or a bad wrap is seen in the very next sample.

A day-end flag that decodes the wrong state disagrees with the time in the same cycle. Stepping through a full day compares every one of the 86400 states, together with the flag, against an arithmetic model.

Sweeping each field over all of its write codes shows, one cycle after each write, any wrong acceptance decision or any leak into fields that were not selected.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int FIELDS  = 3;
  localparam int DIGIT_W = 4;
  localparam int FIELD_W = 2 * DIGIT_W;
  localparam int TIME_W  = 22;

  typedef logic [FIELD_W-1:0] bcd_pair_t;

  // per-field limits and placement: index 0 seconds, 1 minutes, 2 hours
  localparam bcd_pair_t FIELD_LIMIT [FIELDS] = '{8'h59, 8'h59, 8'h23};
  localparam int        FIELD_LSB   [FIELDS] = '{0, 8, 16};
  localparam int        FIELD_BITS  [FIELDS] = '{8, 8, 6};

  localparam logic [DIGIT_W-1:0] DIGIT_MAX = DIGIT_W'(9);

  function automatic bcd_pair_t bcd_next(input bcd_pair_t v);
    logic [DIGIT_W-1:0] lo, hi;
    lo = v[DIGIT_W-1:0];
    hi = v[FIELD_W-1:DIGIT_W];
    if (lo == DIGIT_MAX) return {hi + DIGIT_W'(1), {DIGIT_W{1'b0}}};
    return {hi, lo + DIGIT_W'(1)};
  endfunction
endpackage

// File: rtl/tod_field_guard.sv
module tod_field_guard
  import tod_pkg::*;
#(
  parameter bcd_pair_t LIMIT = 8'h59
) (
  input  bcd_pair_t cand,
  output logic      legal
);
  logic lo_ok, range_ok;

  always_comb begin
    lo_ok    = (cand[DIGIT_W-1:0] <= DIGIT_MAX);
    range_ok = (cand <= LIMIT);
    legal    = lo_ok && range_ok;
  end
endmodule

// File: rtl/tod_field_counter.sv
module tod_field_counter
  import tod_pkg::*;
#(
  parameter bcd_pair_t LIMIT = 8'h59
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  bcd_pair_t load_val,
  input  logic      step,
  output bcd_pair_t value,
  output logic      at_limit,
  output logic      carry
);
  bcd_pair_t value_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value_q <= '0;
    else if (load)     value_q <= load_val;
    else if (step)     value_q <= at_limit ? '0 : bcd_next(value_q);
  end

  assign value    = value_q;
  assign at_limit = (value_q == LIMIT);
  assign carry    = step && at_limit && !load;

  // field digits always legal for its range
  p_field_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (value_q[DIGIT_W-1:0] <= DIGIT_MAX) && (value_q <= LIMIT));

  // idle field holds
  p_field_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(value_q));

  // wrap to zero after limit
  p_field_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && at_limit) |=> (value_q == '0));
endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [FIELDS-1:0] wr_field_en,
  input  logic [TIME_W-1:0] wr_time,
  output logic [TIME_W-1:0] time_now,
  output logic              day_last
);
  logic [FIELDS-1:0] step, carry, at_lim, legal, load;

  // a write in this cycle drops the strobe
  assign step[0] = sec_tick && !wr_en;

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    localparam int LSB  = FIELD_LSB[g];
    localparam int BITS = FIELD_BITS[g];
    logic [BITS-1:0] raw;
    bcd_pair_t       cand, value;

    assign raw  = wr_time[LSB +: BITS];
    assign cand = FIELD_W'(raw);

    tod_field_guard #(.LIMIT(FIELD_LIMIT[g])) u_guard (
      .cand  (cand),
      .legal (legal[g])
    );

    assign load[g] = wr_en && wr_field_en[g] && legal[g];

    if (g > 0) begin : g_chain
      assign step[g] = carry[g-1];
    end

    tod_field_counter #(.LIMIT(FIELD_LIMIT[g])) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load[g]),
      .load_val (cand),
      .step     (step[g]),
      .value    (value),
      .at_limit (at_lim[g]),
      .carry    (carry[g])
    );

    assign time_now[LSB +: BITS] = value[BITS-1:0];

    if (BITS < FIELD_W) begin : g_narrow
      p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        value[FIELD_W-1:BITS] == '0);
    end
  end

  assign day_last = &at_lim;

  // full-day wrap returns to midnight
  p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    carry[FIELDS-1] |=> (time_now == '0));

  p_day_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    day_last |-> (time_now == 22'h235959));

  // unselected seconds do not move during a write
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_field_en[0]) |=> (time_now[7:0] == $past(time_now[7:0])));

  p_min_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field_en[1] && legal[1]) |=> (time_now[15:8] == $past(wr_time[15:8])));
endmodule

// File: tb/tod_bcd_counter_bench.sv
module tod_bcd_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_field_en = '0;
  logic [21:0] wr_time = '0;
  logic [21:0] time_now;
  logic        day_last;

  int checks = 0;
  int fails  = 0;
  int mh = 0, mm = 0, ms = 0;

  always #10 clk = ~clk;

  tod_bcd_counter u_tod_bcd_counter (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_field_en(wr_field_en), .wr_time(wr_time),
    .time_now(time_now), .day_last(day_last)
  );

  function automatic logic [7:0] to_bcd(input int x);
    return 8'((x / 10) * 16 + (x % 10));
  endfunction

  function automatic logic [21:0] model_time();
    logic [7:0] hb;
    hb = to_bcd(mh);
    return {hb[5:0], to_bcd(mm), to_bcd(ms)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_now(input string req);
    check(req, 32'(time_now), 32'(model_time()));
    check({req, " day_last"}, 32'(day_last), 32'(mh == 23 && mm == 59 && ms == 59));
  endtask

  // write at negedge, result visible at the following negedge
  task automatic host_write(input logic [2:0] fe, input logic [21:0] d, input logic tk);
    int v;
    wr_en = 1'b1; wr_field_en = fe; wr_time = d; sec_tick = tk;
    @(negedge clk);
    wr_en = 1'b0; wr_field_en = '0; sec_tick = 1'b0;
    v = int'(d[7:0]);
    if (fe[0] && (v % 16) <= 9 && (v / 16) <= 5) ms = (v / 16) * 10 + v % 16;
    v = int'(d[15:8]);
    if (fe[1] && (v % 16) <= 9 && (v / 16) <= 5) mm = (v / 16) * 10 + v % 16;
    v = int'(d[21:16]);
    if (fe[2] && (v % 16) <= 9 && v <= 8'h23) mh = (v / 16) * 10 + v % 16;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_now("R1 after release");

    // R2 no strobe holds
    repeat (4) @(negedge clk);
    check_now("R2 idle hold");

    // R2 R3 R4 R9: a full day stepped every cycle
    sec_tick = 1'b1;
    for (int i = 0; i < 86400; i++) begin
      @(negedge clk);
      ms++;
      if (ms == 60) begin ms = 0; mm++; end
      if (mm == 60) begin mm = 0; mh++; end
      if (mh == 24) mh = 0;
      check_now("R4 R3 R2 day sweep");
    end
    sec_tick = 1'b0;

    // R10 layout: load 12:34:56
    host_write(3'b111, 22'h123456, 1'b0);
    check_now("R10 full write");

    // R5 R7 R8: sweep seconds codes, junk in other fields
    for (int v = 0; v < 256; v++) begin
      host_write(3'b001, {6'h3F, 8'hFF, 8'(v)}, 1'(v % 2));
      check_now("R5 R7 R8 seconds sweep");
    end
    host_write(3'b001, 22'h000030, 1'b0);
    host_write(3'b001, 22'h00006A, 1'b0);
    check(" R5 reject 0x6A", 32'(time_now[7:0]), 32'h30);

    // R5 R7 minutes sweep
    for (int v = 0; v < 256; v++) begin
      host_write(3'b010, {6'h3F, 8'(v), 8'hFF}, 1'(v % 3 == 0));
      check_now("R5 R7 minutes sweep");
    end

    // R6 hours sweep
    for (int v = 0; v < 64; v++) begin
      host_write(3'b100, {6'(v), 8'hFF, 8'hFF}, 1'b1);
      check_now("R6 hours sweep");
    end

    // R7 minutes-only partial write
    host_write(3'b111, 22'h081520, 1'b0);
    host_write(3'b010, 22'h004711, 1'b1);
    check(" R7 minutes only", 32'(time_now), 32'h084720);

    // R8 strobe dropped then resumes
    @(negedge clk);
    check(" R8 no advance", 32'(time_now), 32'h084720);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    check(" R2 single step", 32'(time_now), 32'h084721);

    // R9 R4 wrap from written 23:59:59
    host_write(3'b111, 22'h235959, 1'b0);
    check(" R9 flag high", 32'(day_last), 32'h1);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    check(" R4 midnight", 32'(time_now), 32'h0);
    check(" R9 flag low", 32'(day_last), 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule